// File: doc/BRIEF.md
# Shared-Pool Dynamic-Threshold Admission Controller

This block keeps the byte accounting for a set of virtual output queues that all draw on one shared packet buffer, and decides for each arriving packet whether it may enter its queue. A queue is named by the triple of ingress port, egress port and priority class. The caller presents an enqueue request with the queue triple and the packet length. The verdict, admit or drop, comes back combinationally in the same cycle. An admitted request is committed at the next clock edge. A separate release port returns bytes when a packet leaves a queue.

The admission limit of a queue is not fixed. It is the per-queue guaranteed reservation plus a fraction (alpha) of the pool space still free. A queue that grows therefore meets a lower ceiling as the whole pool fills, which keeps one congested queue from taking the entire buffer. Alpha is given as a signed power-of-two shift, so no multiplier is needed. Packet storage, link lists and the choice of which queue to serve belong to other blocks. Here only the per-queue byte depths, the pool total, a drop counter, a peak-usage register and a sticky release-error flag are kept.

Top module: `sbdt_admission`

## Requirements
- R1: Each queue is addressed by (ingress port, egress port, priority). Queues that differ in any one of the three fields keep separate depths. The flat index is (ingress × N_OUT + egress) × N_PRIO + priority.
- R2: While `enq_req` is high, exactly one of `enq_admit` and `enq_drop` is high in the same cycle. `enq_admit` is high only when depth + length ≤ reservation + alpha × free space. While `enq_req` is low, both are low.
- R3: On an admitted request, the queue depth and `pool_used` each grow by the packet length at the next rising clock edge.
- R4: A release on `deq_valid` lowers the addressed queue depth and `pool_used` by `deq_len` at the next rising clock edge.
- R5: A dropped request changes neither any queue depth nor `pool_used`.
- R6: `cfg_alpha_shift` is a signed 4-bit value k. For k ≥ 0, alpha = 2^-k (free space shifted right by k). For k < 0, alpha = 2^|k| (free space shifted left by |k|).
- R7: An admission and a release in the same cycle are both applied, and the net change is written. This also holds when both target the same queue, in which case the release may use bytes admitted in that same cycle.
- R8: A release larger than the bytes in the queue (including bytes admitted in that cycle) sets the sticky `deq_err` flag. It leaves the depth at zero and lowers `pool_used` only by the bytes that were actually present.
- R9: `drop_count` increments by one per drop and saturates at its maximum. `peak_used` holds the largest `pool_used` seen since reset.
- R10: Free space is `cfg_pool_bytes` − `pool_used`, or zero once `pool_used` has reached or passed the pool size. In that case, only the reservation remains.
- R11: After reset, all depths, `pool_used`, `peak_used` and `drop_count` are zero and `deq_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pool_bytes | input | CW | Size of the shared pool in bytes |
| cfg_resv_bytes | input | CW | Guaranteed bytes per queue |
| cfg_alpha_shift | input | 4 | Signed alpha exponent (R6) |
| enq_req | input | 1 | Enqueue request |
| enq_in | input | IW | Ingress port of the request |
| enq_out | input | OW | Egress port of the request |
| enq_pri | input | PW | Priority of the request |
| enq_len | input | LW | Packet length in bytes |
| enq_admit | output | 1 | Request admitted (committed at next edge) |
| enq_drop | output | 1 | Request refused |
| enq_depth | output | CW | Current depth of the queue addressed by the enqueue port |
| deq_valid | input | 1 | Release strobe |
| deq_in | input | IW | Ingress port of the release |
| deq_out | input | OW | Egress port of the release |
| deq_pri | input | PW | Priority of the release |
| deq_len | input | LW | Bytes released |
| pool_used | output | CW | Bytes held in the pool |
| peak_used | output | CW | Highest pool usage since reset |
| drop_count | output | DCW | Saturating count of drops |
| deq_err | output | 1 | Sticky over-release flag |

## Verification
The admission test is first probed with directed lengths on each side of the exact threshold: one byte over the limit, then exactly at it. The same is done once the pool is overcommitted, which tells the `<` comparison apart from `≤` and shows that free space floors at zero. Separate phases use alpha shifts of −1, 0, 1 and 2. Because each shift yields a different limit for the same occupancy, they separate right shift from left shift and show whether the sign is handled. A long randomised phase then mixes requests and releases over a few colliding queues, including same-queue enqueue-plus-release cycles, so that every net update is compared against the behavioural model. A final over-release exposes the clamping and the sticky error.

// File: rtl/sbdt_pkg.sv
package sbdt_pkg;

  typedef logic signed [3:0] alpha_shift_t;

  // Flat queue number from the (ingress, egress, priority) triple.
  function automatic int unsigned qflat(input int unsigned ip, input int unsigned op,
                                        input int unsigned pr, input int unsigned n_out,
                                        input int unsigned n_pri);
    return (ip * n_out + op) * n_pri + pr;
  endfunction

endpackage

// File: rtl/sbdt_limit_calc.sv
module sbdt_limit_calc #(
  parameter int CW = 26,
  parameter int LW = 14
) (
  input  logic [CW-1:0]               pool_bytes,
  input  logic [CW-1:0]               resv_bytes,
  input  sbdt_pkg::alpha_shift_t      alpha_shift,
  input  logic [CW-1:0]               used,
  input  logic [CW-1:0]               depth,
  input  logic [LW-1:0]               len,
  input  logic                        req,
  output logic                        admit
);
  localparam int LIMW = CW + 10;

  function automatic logic [CW-1:0] free_space(input logic [CW-1:0] pool, input logic [CW-1:0] u);
    return (u >= pool) ? '0 : pool - u;
  endfunction

  function automatic logic [LIMW-1:0] scaled_share(input logic [CW-1:0] fr,
                                                   input sbdt_pkg::alpha_shift_t sh);
    logic [LIMW-1:0] w;
    int s;
    w = LIMW'(fr);
    s = int'(sh);
    if (s >= 0) return w >> s;
    else        return w << (-s);
  endfunction

  logic [LIMW-1:0] limit;
  logic [LIMW-1:0] need;

  always_comb begin
    limit = LIMW'(resv_bytes) + scaled_share(free_space(pool_bytes, used), alpha_shift);
    need  = LIMW'(depth) + LIMW'(len);
    admit = req && (need <= limit);
  end

endmodule

// File: rtl/sbdt_depth_table.sv
module sbdt_depth_table #(
  parameter int NQ = 32,
  parameter int CW = 26,
  parameter int LW = 14,
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] enq_idx,
  input  logic          add_en,
  input  logic [LW-1:0] add_len,
  input  logic [QW-1:0] deq_idx,
  input  logic          deq_en,
  input  logic [LW-1:0] deq_len,
  output logic [CW-1:0] enq_depth,
  output logic [LW-1:0] rel_len,
  output logic          under
);
  logic [CW-1:0] depth_q [NQ];
  logic [CW:0]   have;

  always_comb begin
    enq_depth = depth_q[enq_idx];
    have      = {1'b0, depth_q[deq_idx]} +
                ((add_en && (enq_idx == deq_idx)) ? (CW+1)'(add_len) : '0);
    under     = deq_en && (have < (CW+1)'(deq_len));
    rel_len   = under ? have[LW-1:0] : deq_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) depth_q[q] <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if ((add_en && enq_idx == QW'(q)) || (deq_en && deq_idx == QW'(q)))
          depth_q[q] <= depth_q[q]
                      + ((add_en && enq_idx == QW'(q)) ? CW'(add_len) : '0)
                      - ((deq_en && deq_idx == QW'(q)) ? CW'(rel_len) : '0);
      end
    end
  end

endmodule

// File: rtl/sbdt_pool_stats.sv
module sbdt_pool_stats #(
  parameter int CW  = 26,
  parameter int LW  = 14,
  parameter int DCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           add_en,
  input  logic [LW-1:0]  add_len,
  input  logic           rel_en,
  input  logic [LW-1:0]  rel_len,
  input  logic           drop_evt,
  input  logic           under_evt,
  output logic [CW-1:0]  used_q,
  output logic [CW-1:0]  peak_q,
  output logic [DCW-1:0] drops_q,
  output logic           err_q
);
  logic [CW-1:0] used_nxt;

  always_comb begin
    used_nxt = used_q + (add_en ? CW'(add_len) : '0) - (rel_en ? CW'(rel_len) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= '0;
      peak_q  <= '0;
      drops_q <= '0;
      err_q   <= 1'b0;
    end else begin
      used_q <= used_nxt;
      if (used_nxt > peak_q) peak_q <= used_nxt;
      if (drop_evt && drops_q != '1) drops_q <= drops_q + 1'b1;
      if (under_evt) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sbdt_admission.sv
module sbdt_admission #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int N_PRIO = 2,
  parameter int CW     = 26,
  parameter int LW     = 14,
  parameter int DCW    = 16,
  localparam int IW    = $clog2(N_IN),
  localparam int OW    = $clog2(N_OUT),
  localparam int PW    = $clog2(N_PRIO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cfg_pool_bytes,
  input  logic [CW-1:0]     cfg_resv_bytes,
  input  logic signed [3:0] cfg_alpha_shift,
  input  logic              enq_req,
  input  logic [IW-1:0]     enq_in,
  input  logic [OW-1:0]     enq_out,
  input  logic [PW-1:0]     enq_pri,
  input  logic [LW-1:0]     enq_len,
  output logic              enq_admit,
  output logic              enq_drop,
  output logic [CW-1:0]     enq_depth,
  input  logic              deq_valid,
  input  logic [IW-1:0]     deq_in,
  input  logic [OW-1:0]     deq_out,
  input  logic [PW-1:0]     deq_pri,
  input  logic [LW-1:0]     deq_len,
  output logic [CW-1:0]     pool_used,
  output logic [CW-1:0]     peak_used,
  output logic [DCW-1:0]    drop_count,
  output logic              deq_err
);
  localparam int NQ = N_IN * N_OUT * N_PRIO;
  localparam int QW = $clog2(NQ);

  // Named internal events for the checker.
  logic [QW-1:0] enq_idx, deq_idx;
  logic          evt_admit, evt_under;
  logic [LW-1:0] rel_len;

  assign enq_idx = QW'(sbdt_pkg::qflat(int'(enq_in), int'(enq_out), int'(enq_pri), N_OUT, N_PRIO));
  assign deq_idx = QW'(sbdt_pkg::qflat(int'(deq_in), int'(deq_out), int'(deq_pri), N_OUT, N_PRIO));

  sbdt_limit_calc #(.CW(CW), .LW(LW)) limit_i (
    .pool_bytes (cfg_pool_bytes),
    .resv_bytes (cfg_resv_bytes),
    .alpha_shift(cfg_alpha_shift),
    .used       (pool_used),
    .depth      (enq_depth),
    .len        (enq_len),
    .req        (enq_req),
    .admit      (evt_admit)
  );

  assign enq_admit = evt_admit;
  assign enq_drop  = enq_req && !evt_admit;

  sbdt_depth_table #(.NQ(NQ), .CW(CW), .LW(LW), .QW(QW)) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_idx  (enq_idx),
    .add_en   (evt_admit),
    .add_len  (enq_len),
    .deq_idx  (deq_idx),
    .deq_en   (deq_valid),
    .deq_len  (deq_len),
    .enq_depth(enq_depth),
    .rel_len  (rel_len),
    .under    (evt_under)
  );

  sbdt_pool_stats #(.CW(CW), .LW(LW), .DCW(DCW)) stats_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (evt_admit),
    .add_len  (enq_len),
    .rel_en   (deq_valid),
    .rel_len  (rel_len),
    .drop_evt (enq_drop),
    .under_evt(evt_under),
    .used_q   (pool_used),
    .peak_q   (peak_used),
    .drops_q  (drop_count),
    .err_q    (deq_err)
  );

endmodule

// File: rtl/sbdt_admission_chk.sv
module sbdt_admission_chk #(
  parameter int CW  = 26,
  parameter int LW  = 14,
  parameter int DCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enq_req,
  input logic           enq_admit,
  input logic           enq_drop,
  input logic [LW-1:0]  enq_len,
  input logic           deq_valid,
  input logic [LW-1:0]  rel_len,
  input logic [CW-1:0]  pool_used,
  input logic [CW-1:0]  peak_used,
  input logic [DCW-1:0] drop_count,
  input logic           deq_err
);

  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_req |-> (enq_admit ^ enq_drop));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_req |-> (!enq_admit && !enq_drop));

  p_pool_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_admit && !deq_valid) |=> pool_used == $past(pool_used) + CW'($past(enq_len)));

  p_pool_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_admit && deq_valid) |=> pool_used == $past(pool_used) - CW'($past(rel_len)));

  p_drop_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_drop && !deq_valid) |=> $stable(pool_used));

  p_net_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_admit && deq_valid) |=>
      pool_used == $past(pool_used) + CW'($past(enq_len)) - CW'($past(rel_len)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deq_err |=> deq_err);

  p_peak_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    peak_used >= pool_used);

  p_drop_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_drop && drop_count != '1) |=> drop_count == $past(drop_count) + 1'b1);

endmodule

bind sbdt_admission sbdt_admission_chk #(.CW(CW), .LW(LW), .DCW(DCW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_req   (enq_req),
  .enq_admit (enq_admit),
  .enq_drop  (enq_drop),
  .enq_len   (enq_len),
  .deq_valid (deq_valid),
  .rel_len   (rel_len),
  .pool_used (pool_used),
  .peak_used (peak_used),
  .drop_count(drop_count),
  .deq_err   (deq_err)
);

// File: tb/sbdt_admission_tb_top.sv
`timescale 1ns/1ps
module sbdt_admission_tb_top;
  localparam int NI = 4, NO = 4, NP = 2, CW = 26, LW = 14, DCW = 16;
  localparam int IW = 2, OW = 2, PW = 1;
  localparam int NQ = NI * NO * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_pool_bytes = '0, cfg_resv_bytes = '0;
  logic signed [3:0] cfg_alpha_shift = '0;
  logic enq_req = 1'b0, deq_valid = 1'b0;
  logic [IW-1:0] enq_in = '0, deq_in = '0;
  logic [OW-1:0] enq_out = '0, deq_out = '0;
  logic [PW-1:0] enq_pri = '0, deq_pri = '0;
  logic [LW-1:0] enq_len = '0, deq_len = '0;
  logic enq_admit, enq_drop, deq_err;
  logic [CW-1:0] enq_depth, pool_used, peak_used;
  logic [DCW-1:0] drop_count;

  always #2.5 clk = ~clk;

  sbdt_admission dut_i (.*);

  int errors = 0, checks = 0;
  bit finished = 0;
  longint m_dep [NQ];
  longint m_used, m_peak, m_drops;
  bit m_err;

  task automatic chk(input string tag, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) m_dep[q] = 0;
    m_used = 0; m_peak = 0; m_drops = 0; m_err = 0;
  endtask

  function automatic int qnum(input int i, input int o, input int p);
    return i * NO * NP + o * NP + p;
  endfunction

  // One clock: drive at negedge, check verdict, advance, check state.
  task automatic step(input string tag, input bit er, input int ei, input int eo, input int ep,
                      input int el, input bit dv, input int di, input int dout, input int dp,
                      input int dl);
    longint freeb, lim, share, add, have, rel;
    int qe, qd, sh;
    bit exp_ok;
    enq_req = er; enq_in = IW'(ei); enq_out = OW'(eo); enq_pri = PW'(ep); enq_len = LW'(el);
    deq_valid = dv; deq_in = IW'(di); deq_out = OW'(dout); deq_pri = PW'(dp); deq_len = LW'(dl);
    qe = qnum(ei, eo, ep); qd = qnum(di, dout, dp);
    freeb = (m_used >= longint'(cfg_pool_bytes)) ? 0 : longint'(cfg_pool_bytes) - m_used;
    sh = int'(cfg_alpha_shift);
    share = (sh >= 0) ? (freeb >>> sh) : (freeb <<< (-sh));
    lim = longint'(cfg_resv_bytes) + share;
    exp_ok = er && (m_dep[qe] + el <= lim);
    #1;
    chk(tag, enq_admit, exp_ok, "enq_admit");
    chk(tag, enq_drop, er && !exp_ok, "enq_drop");
    chk(tag, enq_depth, m_dep[qe], "enq_depth");
    @(posedge clk);
    add = exp_ok ? el : 0;
    m_dep[qe] += add;
    if (dv) begin
      have = m_dep[qd];
      rel = (dl > have) ? have : dl;
      if (dl > have) m_err = 1;
      m_dep[qd] -= rel;
    end else rel = 0;
    m_used = m_used + add - rel;
    if (m_used > m_peak) m_peak = m_used;
    if (er && !exp_ok && m_drops < 65535) m_drops++;
    @(negedge clk);
    chk(tag, pool_used, m_used, "pool_used");
    chk(tag, peak_used, m_peak, "peak_used");
    chk(tag, drop_count, m_drops, "drop_count");
    chk(tag, deq_err, m_err, "deq_err");
  endtask

  task automatic idle();
    enq_req = 0; deq_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    model_reset();
    chk("R11", pool_used, 0, "pool_used after reset");
    chk("R11", peak_used, 0, "peak_used after reset");
    chk("R11", drop_count, 0, "drop_count after reset");
    chk("R11", deq_err, 0, "deq_err after reset");
    chk("R11", enq_depth, 0, "enq_depth after reset");
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cfg_pool_bytes = 1000; cfg_resv_bytes = 100; cfg_alpha_shift = 0;
    do_reset();
    // R2/R5: one byte over limit 1100, then exactly at it
    step("R5", 1, 0,0,0, 1101, 0, 0,0,0, 0);
    step("R2", 1, 0,0,0, 1100, 0, 0,0,0, 0);
    // R10: pool overcommitted, only the reservation remains
    step("R10", 1, 1,0,0, 100, 0, 0,0,0, 0);
    step("R10", 1, 1,0,0, 1, 0, 0,0,0, 0);
    // R1: neighbours differing by one field are separate queues
    step("R1", 1, 1,0,1, 100, 0, 0,0,0, 0);
    step("R1", 1, 1,1,0, 0, 0, 0,0,0, 0);
    step("R1", 1, 2,0,0, 0, 0, 0,0,0, 0);
    // R4: releases bring free space back
    step("R4", 0, 0,0,0, 0, 1, 0,0,0, 1100);
    step("R4", 0, 0,0,0, 0, 1, 1,0,0, 100);
    step("R4", 0, 0,0,0, 0, 1, 1,0,1, 100);
    // R6: same occupancy, different alpha shifts
    step("R3", 1, 3,3,1, 300, 0, 0,0,0, 0);
    cfg_alpha_shift = 1;   // limit = 100 + 700/2 = 450; depth 300
    step("R6", 1, 3,3,1, 151, 0, 0,0,0, 0);
    step("R6", 1, 3,3,1, 150, 0, 0,0,0, 0);
    cfg_alpha_shift = -1;  // free 550, limit = 1200; depth 450
    step("R6", 1, 3,3,1, 751, 0, 0,0,0, 0);
    step("R6", 1, 3,3,1, 550, 0, 0,0,0, 0);
    cfg_alpha_shift = 2;
    step("R6", 1, 2,2,0, 101, 0, 0,0,0, 0);
    cfg_alpha_shift = 0;
    // R7: same-queue admit and release, then cross-queue
    step("R7", 1, 3,3,1, 50, 1, 3,3,1, 80);
    step("R7", 1, 0,1,0, 40, 1, 3,3,1, 20);
    step("R7", 1, 0,1,0, 30, 1, 0,1,0, 70);
    // R9: a run of drops
    for (int k = 0; k < 5; k++) step("R9", 1, 0,2,1, 5000, 0, 0,0,0, 0);

    // randomized mixed traffic with alpha sweep
    do_reset();
    cfg_pool_bytes = 4000; cfg_resv_bytes = 200;
    for (int c = 0; c < 3000; c++) begin
      int ei, eo, ep, di, dd, dp, q, dl;
      bit dv;
      if (c % 500 == 0) cfg_alpha_shift = 4'(((c / 500) % 4) - 1);
      ei = $urandom % 2; eo = $urandom % 2; ep = $urandom % 2;
      di = $urandom % 2; dd = $urandom % 2; dp = $urandom % 2;
      q = qnum(di, dd, dp);
      dv = (m_dep[q] > 0) && ($urandom % 3 != 0);
      dl = dv ? int'(1 + ($urandom % m_dep[q])) : 0;
      step("R3", ($urandom % 4) != 0, ei, eo, ep, 1 + int'($urandom % 1500), dv, di, dd, dp, dl);
    end

    // R8: over-release clamps and latches the error
    cfg_alpha_shift = 0;
    step("R8", 0, 0,0,0, 0, 1, 0,0,0, int'(m_dep[0]) + 5);
    step("R8", 0, 0,0,0, 0, 0, 0,0,0, 0);
    step("R8", 1, 0,0,0, 0, 0, 0,0,0, 0);
    idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule